// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the instruction fetch address for a small accumulator-style processor core. Every cycle the decoder presents a set of one-hot-ish control strobes for the instruction being executed. The sequencer then chooses the next fetch address from one of four sources. It steps to the next word when no strobe is active. It builds a far target for a jump or a subroutine entry from an 11-bit immediate and two page bits held in a separate latch. It takes a saved address from an internal return stack when a return form is executed. When the decoder asks to skip, the following instruction is discarded.

Every control transfer and every skip costs two cycles. In the cycle after the transfer, `stall` is high and the block ignores all strobes, so the instruction already fetched behind the transfer is treated as a no-op. Returns come in three forms. One restores the address only. One also delivers an 8-bit literal to the working register. One also raises a one-cycle pulse that re-enables interrupts globally. The return stack holds eight addresses in a ring. A ninth nested call overwrites the oldest entry without any indication.

The interface is plain control: there is no handshake and no back-pressure. The decoder must treat `stall` as the marker of a discarded instruction slot. Strobes are sampled on every rising clock edge once reset is released.

Top module: `pcs_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `fetch_addr` is 0 and `stall`, `gie_set` and `wreg_load` are 0. Reset also empties the return stack.
- R2: In a cycle with `stall` low and no strobe, `fetch_addr` advances by exactly 1 on the next cycle, wrapping from 13'h1FFF to 0.
- R3: A jump (`do_jump`) makes the next `fetch_addr` equal to {page_bits[1:0], imm_addr[10:0]}, with page_bits as bits 12:11. `stall` is high in that cycle and the stack is untouched.
- R4: A call (`do_call`) loads the same target as a jump and sets `stall` for one cycle. It also pushes onto the stack the `fetch_addr` value seen in the call cycle, which is the return address.
- R5: A return (`do_ret`) makes the next `fetch_addr` equal to the most recently pushed and not yet popped address, and sets `stall` for one cycle.
- R6: A return with literal (`do_retlw`) pops as in R5. In the following cycle it also raises `wreg_load` for exactly one cycle with `wreg_data` equal to `ret_literal`.
- R7: A return from interrupt (`do_retfie`) pops as in R5. In the following cycle it raises `gie_set` for exactly one cycle.
- R8: A skip (`skip_req`) lets `fetch_addr` advance by 1 as in R2, but raises `stall` for the next cycle so that the next instruction is discarded.
- R9: `stall` never stays high for two consecutive cycles. In a stall cycle every strobe is ignored and `fetch_addr` advances by 1.
- R10: When several strobes are high together, one wins in this order: call, jump, return, return-with-literal, return-from-interrupt, skip.
- R11: Eight nested calls followed by eight returns give back the eight return addresses in reverse order.
- R12: The stack is a ring of eight entries. After nine nested calls, the ninth push has replaced the first. Nine returns then yield pushes 9, 8, …, 2 and then push 9 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| do_call | input | 1 | Execute a subroutine call |
| do_jump | input | 1 | Execute an absolute jump |
| do_ret | input | 1 | Execute a plain return |
| do_retlw | input | 1 | Execute a return that loads a literal |
| do_retfie | input | 1 | Execute a return from interrupt |
| skip_req | input | 1 | Discard the next instruction |
| imm_addr | input | 11 | Low target bits for jump and call |
| page_bits | input | 2 | High target bits from the page latch |
| ret_literal | input | 8 | Literal for return-with-literal |
| fetch_addr | output | 13 | Instruction fetch address |
| stall | output | 1 | Current slot is a discarded two-cycle slot |
| gie_set | output | 1 | One-cycle pulse to set the global interrupt enable |
| wreg_load | output | 1 | One-cycle pulse to load the working register |
| wreg_data | output | 8 | Literal to load into the working register |

## Verification
The hardest state to reach from the ports is a stack that has wrapped. In that state, the slot the next return reads no longer holds the value that was originally pushed there. Reaching it takes nine calls in a row, each followed by its stall slot, before any return. The stimulus issues those nine calls with distinct page and immediate values and records each `fetch_addr` seen at call time. It then issues nine returns and compares each one against a small eight-slot ring model of pushes. The final return must reproduce the ninth call's address rather than the first.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Resolved action for one execute slot, after priority and stall masking.
  typedef enum logic [2:0] {
    OP_SEQ    = 3'd0,
    OP_SKIP   = 3'd1,
    OP_JUMP   = 3'd2,
    OP_CALL   = 3'd3,
    OP_RET    = 3'd4,
    OP_RETLW  = 3'd5,
    OP_RETFIE = 3'd6
  } pcs_op_e;

  function automatic logic op_pops(pcs_op_e op);
    return (op == OP_RET) || (op == OP_RETLW) || (op == OP_RETFIE);
  endfunction

  function automatic logic op_far(pcs_op_e op);
    return (op == OP_JUMP) || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic    stall_i,
  input  logic    call_i,
  input  logic    jump_i,
  input  logic    ret_i,
  input  logic    retlw_i,
  input  logic    retfie_i,
  input  logic    skip_i,
  output pcs_op_e op_o
);

  // Fixed priority; a discarded slot resolves to a plain step.
  always_comb begin
    op_o = OP_SEQ;
    if (!stall_i) begin
      if (call_i)        op_o = OP_CALL;
      else if (jump_i)   op_o = OP_JUMP;
      else if (ret_i)    op_o = OP_RET;
      else if (retlw_i)  op_o = OP_RETLW;
      else if (retfie_i) op_o = OP_RETFIE;
      else if (skip_i)   op_o = OP_SKIP;
    end
  end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr;

  // Ring pointers: the write pointer names the next free slot.
  assign rd_ptr = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;
  assign top_o  = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push_i) begin
      slot_q[wr_ptr_q] <= data_i;
      wr_ptr_q         <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end else if (pop_i) begin
      wr_ptr_q <= rd_ptr;
    end
  end

endmodule

// File: rtl/pcs_target.sv
module pcs_target
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IMM_W  = 11
) (
  input  pcs_op_e                  op_i,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [ADDR_W-IMM_W-1:0]  page_i,
  input  logic [IMM_W-1:0]         imm_i,
  input  logic [ADDR_W-1:0]        top_i,
  output logic [ADDR_W-1:0]        next_o
);

  logic [ADDR_W-1:0] far_addr;
  logic [ADDR_W-1:0] step_addr;

  assign far_addr  = {page_i, imm_i};
  assign step_addr = pc_i + 1'b1;

  always_comb begin
    if (op_far(op_i))       next_o = far_addr;
    else if (op_pops(op_i)) next_o = top_i;
    else                    next_o = step_addr;
  end

endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
  import pcs_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int IMM_W       = 11,
  parameter int LIT_W       = 8,
  parameter int STACK_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     do_call,
  input  logic                     do_jump,
  input  logic                     do_ret,
  input  logic                     do_retlw,
  input  logic                     do_retfie,
  input  logic                     skip_req,
  input  logic [IMM_W-1:0]         imm_addr,
  input  logic [ADDR_W-IMM_W-1:0]  page_bits,
  input  logic [LIT_W-1:0]         ret_literal,
  output logic [ADDR_W-1:0]        fetch_addr,
  output logic                     stall,
  output logic                     gie_set,
  output logic                     wreg_load,
  output logic [LIT_W-1:0]         wreg_data
);

  pcs_op_e           op;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] top_addr;
  logic              stall_q;
  logic              gie_q;
  logic              wl_q;
  logic [LIT_W-1:0]  wd_q;

  pcs_decode u_dec (
    .stall_i  (stall_q),
    .call_i   (do_call),
    .jump_i   (do_jump),
    .ret_i    (do_ret),
    .retlw_i  (do_retlw),
    .retfie_i (do_retfie),
    .skip_i   (skip_req),
    .op_o     (op)
  );

  // The fetch address during the call slot is the return address.
  pcs_stack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (op == OP_CALL),
    .pop_i  (op_pops(op)),
    .data_i (pc_q),
    .top_o  (top_addr)
  );

  pcs_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_tgt (
    .op_i   (op),
    .pc_i   (pc_q),
    .page_i (page_bits),
    .imm_i  (imm_addr),
    .top_i  (top_addr),
    .next_o (next_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      stall_q <= 1'b0;
      gie_q   <= 1'b0;
      wl_q    <= 1'b0;
      wd_q    <= '0;
    end else begin
      pc_q    <= next_pc;
      stall_q <= (op != OP_SEQ);
      gie_q   <= (op == OP_RETFIE);
      wl_q    <= (op == OP_RETLW);
      if (op == OP_RETLW) wd_q <= ret_literal;
    end
  end

  assign fetch_addr = pc_q;
  assign stall      = stall_q;
  assign gie_set    = gie_q;
  assign wreg_load  = wl_q;
  assign wreg_data  = wd_q;

endmodule

// File: rtl/pcs_sequencer_chk.sv
module pcs_sequencer_chk #(
  parameter int ADDR_W = 13,
  parameter int IMM_W  = 11,
  parameter int LIT_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     do_call,
  input logic                     do_jump,
  input logic                     do_ret,
  input logic                     do_retlw,
  input logic                     do_retfie,
  input logic                     skip_req,
  input logic [IMM_W-1:0]         imm_addr,
  input logic [ADDR_W-IMM_W-1:0]  page_bits,
  input logic [LIT_W-1:0]         ret_literal,
  input logic [ADDR_W-1:0]        fetch_addr,
  input logic                     stall,
  input logic                     gie_set,
  input logic                     wreg_load,
  input logic [LIT_W-1:0]         wreg_data
);

  logic any_op;
  assign any_op = do_call | do_jump | do_ret | do_retlw | do_retfie | skip_req;

  assert_stall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !any_op) |=> (fetch_addr == $past(fetch_addr) + 1'b1) && !stall);

  assert_jump_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && do_jump && !do_call) |=>
      stall && (fetch_addr == {$past(page_bits), $past(imm_addr)}));

  assert_call_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && do_call) |=>
      stall && (fetch_addr == {$past(page_bits), $past(imm_addr)}));

  assert_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && skip_req && !(do_call | do_jump | do_ret | do_retlw | do_retfie)) |=>
      stall && (fetch_addr == $past(fetch_addr) + 1'b1));

  assert_gie_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && do_retfie && !(do_call | do_jump | do_ret | do_retlw)) |=> gie_set && stall);

  assert_gie_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |=> !gie_set);

  assert_wreg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && do_retlw && !(do_call | do_jump | do_ret)) |=>
      wreg_load && (wreg_data == $past(ret_literal)));

  assert_wreg_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wreg_load |=> !wreg_load);

endmodule

bind pcs_sequencer pcs_sequencer_chk #(
  .ADDR_W (ADDR_W),
  .IMM_W  (IMM_W),
  .LIT_W  (LIT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .do_call     (do_call),
  .do_jump     (do_jump),
  .do_ret      (do_ret),
  .do_retlw    (do_retlw),
  .do_retfie   (do_retfie),
  .skip_req    (skip_req),
  .imm_addr    (imm_addr),
  .page_bits   (page_bits),
  .ret_literal (ret_literal),
  .fetch_addr  (fetch_addr),
  .stall       (stall),
  .gie_set     (gie_set),
  .wreg_load   (wreg_load),
  .wreg_data   (wreg_data)
);

// File: tb/sim_pcs_sequencer.sv
`timescale 1ns/1ps
module sim_pcs_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        do_call, do_jump, do_ret, do_retlw, do_retfie, skip_req;
  logic [10:0] imm_addr;
  logic [1:0]  page_bits;
  logic [7:0]  ret_literal;
  logic [12:0] fetch_addr;
  logic        stall, gie_set, wreg_load;
  logic [7:0]  wreg_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pcs_sequencer u0 (
    .clk(clk), .rst_n(rst_n),
    .do_call(do_call), .do_jump(do_jump), .do_ret(do_ret),
    .do_retlw(do_retlw), .do_retfie(do_retfie), .skip_req(skip_req),
    .imm_addr(imm_addr), .page_bits(page_bits), .ret_literal(ret_literal),
    .fetch_addr(fetch_addr), .stall(stall), .gie_set(gie_set),
    .wreg_load(wreg_load), .wreg_data(wreg_data)
  );

  // Vector: [54:51] req, [50:45] {call,jump,ret,retlw,retfie,skip},
  // [44:43] page, [42:32] imm, [31:24] lit, [23:11] next addr,
  // [10] stall, [9] gie_set, [8] wreg_load, [7:0] wreg_data
  localparam int NV = 19;
  localparam logic [54:0] VEC [NV] = '{
    {4'd2,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0001, 1'b0, 1'b0, 1'b0, 8'h00}, // R2
    {4'd2,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0002, 1'b0, 1'b0, 1'b0, 8'h00}, // R2
    {4'd4,  6'b100000, 2'd1, 11'h100, 8'h00, 13'h0900, 1'b1, 1'b0, 1'b0, 8'h00}, // R4
    {4'd9,  6'b010000, 2'd3, 11'h005, 8'h00, 13'h0901, 1'b0, 1'b0, 1'b0, 8'h00}, // R9
    {4'd8,  6'b000001, 2'd0, 11'h000, 8'h00, 13'h0902, 1'b1, 1'b0, 1'b0, 8'h00}, // R8
    {4'd8,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0903, 1'b0, 1'b0, 1'b0, 8'h00}, // R8
    {4'd6,  6'b000100, 2'd0, 11'h000, 8'hA5, 13'h0002, 1'b1, 1'b0, 1'b1, 8'hA5}, // R6
    {4'd6,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0003, 1'b0, 1'b0, 1'b0, 8'h00}, // R6
    {4'd4,  6'b100000, 2'd0, 11'h7FF, 8'h00, 13'h07FF, 1'b1, 1'b0, 1'b0, 8'h00}, // R4
    {4'd2,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0800, 1'b0, 1'b0, 1'b0, 8'h00}, // R2
    {4'd7,  6'b000010, 2'd0, 11'h000, 8'h00, 13'h0003, 1'b1, 1'b1, 1'b0, 8'h00}, // R7
    {4'd7,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0004, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    {4'd10, 6'b111001, 2'd2, 11'h010, 8'h00, 13'h1010, 1'b1, 1'b0, 1'b0, 8'h00}, // R10
    {4'd10, 6'b000000, 2'd0, 11'h000, 8'h00, 13'h1011, 1'b0, 1'b0, 1'b0, 8'h00}, // R10
    {4'd10, 6'b001001, 2'd0, 11'h000, 8'h00, 13'h0004, 1'b1, 1'b0, 1'b0, 8'h00}, // R10
    {4'd5,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0005, 1'b0, 1'b0, 1'b0, 8'h00}, // R5
    {4'd3,  6'b010000, 2'd3, 11'h7FF, 8'h00, 13'h1FFF, 1'b1, 1'b0, 1'b0, 8'h00}, // R3
    {4'd2,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0000, 1'b0, 1'b0, 1'b0, 8'h00}, // R2
    {4'd2,  6'b000000, 2'd0, 11'h000, 8'h00, 13'h0001, 1'b0, 1'b0, 1'b0, 8'h00}  // R2
  };

  logic [12:0] mdl [8];
  int          msp = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    {do_call, do_jump, do_ret, do_retlw, do_retfie, skip_req} = 6'b0;
    imm_addr = '0; page_bits = '0; ret_literal = '0;
  endtask

  task automatic call_to(input logic [12:0] tgt, input string req);
    mdl[msp] = fetch_addr;
    msp = (msp + 1) % 8;
    do_call = 1'b1; page_bits = tgt[12:11]; imm_addr = tgt[10:0];
    @(negedge clk);
    quiet();
    check(fetch_addr == tgt && stall, req, {19'd0, fetch_addr}, {19'd0, tgt});
    @(negedge clk);
  endtask

  task automatic return_to(input string req, output logic [12:0] got);
    logic [12:0] exp;
    msp = (msp + 7) % 8;
    exp = mdl[msp];
    do_ret = 1'b1;
    @(negedge clk);
    quiet();
    got = fetch_addr;
    check(fetch_addr == exp && stall, req, {19'd0, fetch_addr}, {19'd0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [12:0] first_pop, last_pop, got;
    quiet();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(fetch_addr == 0 && !stall && !gie_set && !wreg_load, "R1",
          {19'd0, fetch_addr}, 32'd0);
    rst_n = 1'b1;
    check(fetch_addr == 0 && !stall, "R1", {19'd0, fetch_addr}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      {do_call, do_jump, do_ret, do_retlw, do_retfie, skip_req} = v[50:45];
      page_bits = v[44:43]; imm_addr = v[42:32]; ret_literal = v[31:24];
      @(negedge clk);
      quiet();
      checks++;
      if (fetch_addr !== v[23:11] || stall !== v[10] || gie_set !== v[9] ||
          wreg_load !== v[8] || (v[8] && wreg_data !== v[7:0])) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%0h/%b%b%b/%0h expected=%0h/%b%b%b/%0h",
                 v[54:51], i, fetch_addr, stall, gie_set, wreg_load, wreg_data,
                 v[23:11], v[10], v[9], v[8], v[7:0]);
      end
    end

    // R11: eight nested calls unwind in reverse
    for (int k = 0; k < 8; k++) call_to(13'(k * 13'h311 + 13'h040), "R11");
    for (int k = 0; k < 8; k++) return_to("R11", got);

    // R12: ninth call overwrites the oldest slot
    for (int k = 0; k < 9; k++) call_to(13'(k * 13'h2A3 + 13'h123), "R12");
    for (int k = 0; k < 9; k++) begin
      return_to("R12", got);
      if (k == 0) first_pop = got;
      if (k == 8) last_pop = got;
    end
    check(first_pop == last_pop, "R12", {19'd0, last_pop}, {19'd0, first_pop});

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    check(fetch_addr == 0 && !stall && !gie_set && !wreg_load, "R1",
          {19'd0, fetch_addr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_addr == 1 && !stall, "R2", {19'd0, fetch_addr}, 32'd1);

    summary();
    $finish;
  end

endmodule